// File: doc/BRIEF.md
# Byte-Wide EEPROM Page Load and Program Controller

This block models the write path of a byte-wide parallel EEPROM as a synchronous unit. The host issues single-cycle load strobes, each carrying a byte address and a data byte. The upper address bits select a 64-byte page and the low six bits select a byte within it. Loaded bytes collect in a page buffer that keeps a per-byte valid flag. Every accepted load restarts a quiet-time window. When that window runs out with no further load, the block starts a self-timed programming phase. At the end of that phase, only the flagged bytes are copied into the backing array. All other bytes of the page keep their old contents.

While programming is in progress, `busy` is high and every read returns an end-of-write status byte instead of array data. That status byte has two indicators. Bit 7 is the inverse of bit 7 of the last byte accepted. Bit 6 flips with every read. Once the phase ends, reads return true array contents again. Both the window and the programming time are counted in clock cycles and set by parameters, so a test can run at a reduced scale. The default array is 1024 bytes (`ADDR_W` = 10). Setting `ADDR_W` to 15 gives the full 32K-byte device.

Top module: `eeprom_page_loader`

## Requirements
- R1: After reset, `busy` is low and `rd_data` is 0x00, and no byte is pending in the page buffer.
- R2: Address bits [ADDR_W-1:6] select the page and bits [5:0] select the byte within the page, so each page holds 64 bytes.
- R3: `busy` rises exactly WIN_CYC clock edges after the edge that accepted the last load. Every accepted load restarts this count.
- R4: While bytes are being collected, a load whose page differs from the page of the first load is ignored. It neither changes the buffer nor restarts the window.
- R5: Bytes of a page may be loaded in any order. A byte loaded more than once within the window programs the value of its last load.
- R6: At commit, only bytes flagged as loaded are written to the array. Every other byte of the page keeps its previous value.
- R7: `busy` stays high for exactly PROG_CYC clock cycles. The array holds the new data from the cycle in which `busy` falls.
- R8: A read accepted while `busy` is high returns bit 7 equal to the inverse of bit 7 of the last accepted load data, and bits [5:0] equal to that data's bits [5:0].
- R9: In status reads, bit 6 is 0 on the first read after `busy` rises and alternates on each later read during that phase. After `busy` falls, reads return true data.
- R10: A load strobe that arrives while `busy` is high is ignored. It affects neither the array, nor the status byte, nor the programming time.
- R11: `rd_data` updates one clock after `rd_stb`. When `busy` is low, it returns the array byte at `rd_addr`, including while a page is still being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_stb | input | 1 | Single-cycle byte load strobe |
| ld_addr | input | ADDR_W | Load address (page, byte offset) |
| ld_data | input | 8 | Load data byte |
| rd_stb | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result or status byte, registered |
| busy | output | 1 | High while the programming phase runs |

## Verification
The main function is exercised with three load patterns:
- A two-byte page with a late second load. This shows the window restarts on an accepted load rather than counting from the first one.
- A full 64-byte fill in descending offset order. This confirms ordering is free and sets known contents for the whole page.
- A sparse reload of that page with a repeated offset, a stray load to another page and a load inside the programming phase. This separates last-value-wins, partial commit and the two kinds of ignored strobe.

Status reads taken during programming confirm both the inverted polling bit and the alternating bit.

// File: rtl/eeprom_pl_pkg.sv
package eeprom_pl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pl_state_e;
endpackage

// File: rtl/pl_cycle_timer.sv
module pl_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pl_page_buffer.sv
module pl_page_buffer #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0]  wr_off,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           clr,
  output logic [PAGE_BYTES*DATA_W-1:0]   bytes_flat,
  output logic [PAGE_BYTES-1:0]          valid
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  for (genvar j = 0; j < PAGE_BYTES; j++) begin : g_slot
    logic              hit;
    logic [DATA_W-1:0] byte_q;
    logic              vld_q, vld_d;

    assign hit = wr_en && (wr_off == OFF_W'(j));

    always_comb begin
      vld_d = vld_q;
      if (clr)      vld_d = 1'b0;
      else if (hit) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= vld_d;
        if (hit) byte_q <= wr_data;
      end
    end

    assign bytes_flat[j*DATA_W +: DATA_W] = byte_q;
    assign valid[j] = vld_q;
  end
endmodule

// File: rtl/pl_mem_array.sv
module pl_mem_array #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8
) (
  input  logic                                       clk,
  input  logic                                       commit,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]       page,
  input  logic [PAGE_BYTES*DATA_W-1:0]               bytes_flat,
  input  logic [PAGE_BYTES-1:0]                      valid,
  input  logic [ADDR_W-1:0]                          rd_addr,
  output logic [DATA_W-1:0]                          rd_byte
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int j = 0; j < PAGE_BYTES; j++) begin
        if (valid[j]) mem[{page, OFF_W'(j)}] <= bytes_flat[j*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader
  import eeprom_pl_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WIN_CYC  = 18750,
  parameter int PROG_CYC = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int PAGE_BYTES = 64;
  localparam int DATA_W     = 8;
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = ADDR_W - OFF_W;

  // reset synchronizer: assert asynchronously, release on clock
  logic rs0_q, rs1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rs1_q, rs0_q} <= 2'b00;
    else        {rs1_q, rs0_q} <= {rs0_q, 1'b1};
  end
  assign rst_sync_n = rs1_q;

  pl_state_e           state_q, state_d;
  logic [PAGE_W-1:0]   page_q, page_d;
  logic [7:0]          last_q, last_d;
  logic                tog_q, tog_d;
  logic [7:0]          rdat_q, rdat_d;

  logic [PAGE_W-1:0]   ld_page;
  logic [OFF_W-1:0]    ld_off;
  logic                accept, win_done, prog_done, expire, commit;
  logic [PAGE_BYTES*DATA_W-1:0] buf_flat;
  logic [PAGE_BYTES-1:0]        buf_valid;
  logic [7:0]          arr_byte;

  assign ld_page = ld_addr[ADDR_W-1:OFF_W];
  assign ld_off  = ld_addr[OFF_W-1:0];

  assign accept = ld_stb && ((state_q == ST_IDLE) ||
                             ((state_q == ST_LOAD) && (ld_page == page_q)));
  assign expire = (state_q == ST_LOAD) && win_done && !accept;
  assign commit = (state_q == ST_PROG) && prog_done;
  assign busy   = (state_q == ST_PROG);

  pl_cycle_timer #(.LIMIT(WIN_CYC)) u_win_tmr (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(accept), .en(state_q == ST_LOAD), .done(win_done)
  );

  pl_cycle_timer #(.LIMIT(PROG_CYC)) u_prog_tmr (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(state_q != ST_PROG), .en(state_q == ST_PROG), .done(prog_done)
  );

  pl_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_pbuf (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(accept), .wr_off(ld_off), .wr_data(ld_data),
    .clr(commit), .bytes_flat(buf_flat), .valid(buf_valid)
  );

  pl_mem_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .commit(commit), .page(page_q),
    .bytes_flat(buf_flat), .valid(buf_valid),
    .rd_addr(rd_addr), .rd_byte(arr_byte)
  );

  always_comb begin
    state_d = state_q;
    page_d  = page_q;
    last_d  = last_q;
    tog_d   = tog_q;
    rdat_d  = rdat_q;

    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOAD;
      ST_LOAD: if (expire) state_d = ST_PROG;
      ST_PROG: if (commit) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    if (accept) begin
      last_d = ld_data;
      if (state_q == ST_IDLE) page_d = ld_page;
    end

    if (rd_stb) begin
      if (busy) begin
        rdat_d = {~last_q[7], tog_q, last_q[5:0]};
        tog_d  = ~tog_q;
      end else begin
        rdat_d = arr_byte;
      end
    end

    if (expire) tog_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      last_q  <= '0;
      tog_q   <= 1'b0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      last_q  <= last_d;
      tog_q   <= tog_d;
      rdat_q  <= rdat_d;
    end
  end

  assign rd_data = rdat_q;
endmodule

// File: rtl/eeprom_page_loader_chk.sv
module eeprom_page_loader_chk #(
  parameter int WIN_CYC  = 18750,
  parameter int PROG_CYC = 1250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       accept,
  input logic       rd_stb,
  input logic [7:0] rd_data,
  input logic [7:0] last_data
);
  localparam int QW = $clog2(WIN_CYC + 2);
  localparam int BW = $clog2(PROG_CYC + 2);

  logic [QW-1:0] quiet_q;
  logic [BW-1:0] blen_q;

  // cycles since the last accepted load, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           quiet_q <= '0;
    else if (accept)                      quiet_q <= '0;
    else if (quiet_q != QW'(WIN_CYC + 1)) quiet_q <= quiet_q + 1'b1;
  end

  // length of the current busy phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            blen_q <= '0;
    else if (!busy)                        blen_q <= '0;
    else if (blen_q != BW'(PROG_CYC + 1))  blen_q <= blen_q + 1'b1;
  end

  // R3: programming starts after exactly WIN_CYC quiet edges
  p_window_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (quiet_q == QW'(WIN_CYC)));

  // R7: busy lasts exactly PROG_CYC cycles
  p_prog_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen_q == BW'(PROG_CYC)));

  // R10: no load is taken while programming
  p_no_load_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  // R8: status read inverts bit 7 of the last loaded byte
  p_poll_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_stb) && $past(busy)) |-> (rd_data[7] != last_data[7]));
endmodule

bind eeprom_page_loader eeprom_page_loader_chk #(
  .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .accept(accept),
  .rd_stb(rd_stb), .rd_data(rd_data), .last_data(last_q)
);

// File: tb/eeprom_page_loader_bench.sv
`timescale 1ns/1ps
module eeprom_page_loader_bench;
  localparam int ADDR_W = 10;
  localparam int WIN    = 20;
  localparam int PROG   = 50;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ld_stb;
  logic [ADDR_W-1:0] ld_addr;
  logic [7:0]        ld_data;
  logic              rd_stb;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              busy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #4 clk = ~clk;

  eeprom_page_loader #(.ADDR_W(ADDR_W), .WIN_CYC(WIN), .PROG_CYC(PROG)) u_eeprom_page_loader (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  function automatic logic [ADDR_W-1:0] ad(int page, int off);
    return ADDR_W'((page << 6) | off);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic load(int page, int off, logic [7:0] d);
    @(negedge clk);
    ld_stb = 1'b1; ld_addr = ad(page, off); ld_data = d;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  // driver: pushes the expected byte, monitor compares it
  task automatic rd(int page, int off, logic [7:0] exp, string req);
    @(negedge clk);
    exp_q.push_back('{exp: exp, req: req});
    rd_stb = 1'b1; rd_addr = ad(page, off);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wait_busy(logic lvl, string req);
    int k;
    for (k = 0; k < 5000 && busy !== lvl; k++) @(negedge clk);
    if (busy !== lvl) chk(req, {7'd0, busy}, {7'd0, lvl});
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rd_stb) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("R11 unexpected read", rd_data, 8'hxx);
        else begin
          rd_item_t it;
          it = exp_q.pop_front();
          chk(it.req, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_stb = 1'b0; ld_addr = '0; ld_data = '0; rd_stb = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", {7'd0, busy}, 8'h00);
    chk("R1 rd_data after reset", rd_data, 8'h00);

    // page 4: window restart then exact timing
    load(4, 1, 8'h11);
    repeat (WIN - 3) @(negedge clk);
    load(4, 2, 8'h22);
    repeat (WIN - 1) @(negedge clk);
    chk("R3 busy before window end", {7'd0, busy}, 8'h00);
    @(negedge clk);
    chk("R3 busy at window end", {7'd0, busy}, 8'h01);
    repeat (PROG - 1) @(negedge clk);
    chk("R7 busy before program end", {7'd0, busy}, 8'h01);
    @(negedge clk);
    chk("R7 busy after program end", {7'd0, busy}, 8'h00);
    rd(4, 1, 8'h11, "R2 page4 byte1");
    rd(4, 2, 8'h22, "R7 page4 byte2");

    // page 3: full fill, descending order
    for (int o = 63; o >= 0; o--) load(3, o, 8'(o) ^ 8'h5A);
    wait_busy(1'b1, "R3 fill start");
    wait_busy(1'b0, "R7 fill end");
    rd(3, 0, 8'h5A, "R5 fill byte0");
    rd(3, 63, 8'h65, "R5 fill byte63");

    // page 3: sparse reload with stray and busy-time loads
    load(3, 5, 8'h10);
    rd(3, 5, 8'h5F, "R11 read during collection");
    load(3, 0, 8'hC3);
    load(4, 1, 8'hEE);
    load(3, 63, 8'h7E);
    load(3, 5, 8'h81);
    wait_busy(1'b1, "R3 sparse start");
    rd(3, 20, 8'h01, "R8 status read 1");
    rd(3, 20, 8'h41, "R9 status read 2");
    load(3, 10, 8'h99);
    rd(2, 0, 8'h01, "R10 status after busy load");
    wait_busy(1'b0, "R7 sparse end");
    rd(3, 5, 8'h81, "R5 last value wins");
    rd(3, 0, 8'hC3, "R9 true data after completion");
    rd(3, 63, 8'h7E, "R6 loaded byte63");
    rd(3, 10, 8'h50, "R10 busy load ignored");
    rd(3, 7, 8'h5D, "R6 unloaded byte kept");
    rd(4, 1, 8'h11, "R4 other page untouched");
    rd(4, 2, 8'h22, "R4 other page byte2");
    repeat (4) @(negedge clk);
    chk("R11 all reads answered", 8'(exp_q.size()), 8'h00);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule